// File: doc/BRIEF.md
# Single-Descriptor Flash DMA Engine

This block moves one flash data transfer between system memory and the flash controller's data path. Software places a four-word descriptor in memory and writes its address into a base register. The words are a status word, a size word, a primary buffer pointer and a secondary pointer. When the controller issues a data command, the engine reads the descriptor over a 64-bit memory port. It accepts the descriptor only if software still owns nothing of it: the hand-over bit and both single-segment markers must be set. It then streams the buffer in 8-byte beats. A transfer toward the flash (TX) reads memory and presents each beat on a transmit output. A transfer from the flash (RX) takes each beat from a receive input and writes it to memory.

On completion the engine writes the status word back with the hand-over bit cleared, which returns the descriptor to software. It then pulses a direction-specific completion interrupt. A descriptor that is not handed over, or that does not describe one complete segment, raises a separate unavailable pulse and moves no data.

The memory port is a plain request/acknowledge port. The engine holds a request and its controls until the acknowledge arrives, and read data is valid in the acknowledge cycle.

Top module: `ndma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `tx_valid`, `rx_ready` and all three interrupt outputs are 0.
- R2: A configuration write with `cfg_addr` = 0x18 loads the descriptor base register. Writes to any other offset change nothing. The base is sampled when a command starts, so a base write during a transfer does not affect that transfer.
- R3: A command accepted while idle first reads the 64-bit word at the base. Its low 32 bits are the status word and its high 32 bits are the size word. The engine then reads base+8, whose low 32 bits are the buffer pointer; the high 32 bits, the second pointer, are ignored.
- R4: A descriptor is usable only if status bits 31, 3 and 2 are all 1. Otherwise the engine pulses `irq_desc_unavail` for one cycle, returns to idle, and makes no further memory access.
- R5: The beat count is size-word bits [11:3]. Bits above 11 and the low 3 bits are ignored. Beat i uses address pointer + 8*i, in ascending order.
- R6: With `cmd_dir` = 0 (TX), each beat is a memory read whose data appears on `tx_data` with `tx_valid`, held unchanged until `tx_ready`.
- R7: With `cmd_dir` = 1 (RX), each beat is taken from `rx_data` in a cycle where `rx_valid` and `rx_ready` are both 1. It is then written to memory with `mem_be` = 0xFF.
- R8: After the last beat the engine writes the base address with `mem_be` = 0x0F. The low 32 bits of that write are the fetched status word with bit 31 cleared.
- R9: In the cycle after the write-back is acknowledged, exactly one of `irq_tx_done` (TX) or `irq_rx_done` (RX) is 1, for one cycle. The engine is then idle.
- R10: A beat count of zero makes no data access: the buffer-pointer read is followed directly by the write-back and the completion pulse.
- R11: `cmd_start` while `busy` is 1 is ignored.
- R12: Once `mem_req` is 1, it and `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_start | input | 1 | Starts a data command when idle |
| cmd_dir | input | 1 | 0 = memory to flash (TX), 1 = flash to memory (RX) |
| busy | output | 1 | Engine is processing a command |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables of a write |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Transmit beat available |
| tx_data | output | 64 | Transmit beat |
| tx_ready | input | 1 | Transmit side accepts the beat |
| rx_valid | input | 1 | Receive beat available |
| rx_data | input | 64 | Receive beat |
| rx_ready | output | 1 | Engine accepts a receive beat |
| irq_tx_done | output | 1 | One-cycle TX completion pulse |
| irq_rx_done | output | 1 | One-cycle RX completion pulse |
| irq_desc_unavail | output | 1 | One-cycle pulse for an unusable descriptor |

## Verification
The assertions assume the memory side raises `mem_ack` only while `mem_req` is 1 and never in two consecutive cycles. The stimulus meets this with a responder that waits 0 to 2 cycles and leaves a gap after every acknowledge. They also assume the descriptor and buffer addresses are 8-byte aligned; the bench places every descriptor and buffer on such boundaries. The receive source changes `rx_data` only after a beat has been taken, and the transmit sink varies `tx_ready` freely, so the hold rule on the transmit output is exercised under stalls.

// File: rtl/ndma_pkg.sv
package ndma_pkg;
  localparam int SIZE_W    = 12;  // size field width in the size word
  localparam int BEAT_SH   = 3;   // log2 of bytes per 64-bit beat
  localparam int CNT_W     = SIZE_W - BEAT_SH;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 3;
  localparam int LAST_BIT  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_TX_RD, S_TX_PUSH, S_RX_POP, S_RX_WR, S_WBACK
  } ndma_state_t;

  // descriptor may be consumed: handed over and a single complete segment
  function automatic logic desc_usable(input logic [31:0] st);
    return st[OWN_BIT] & st[FIRST_BIT] & st[LAST_BIT];
  endfunction

  // number of 8-byte beats encoded in the size word
  function automatic logic [CNT_W-1:0] beats_of(input logic [31:0] sz);
    return sz[SIZE_W-1:BEAT_SH];
  endfunction

  // status word handed back to software
  function automatic logic [31:0] status_release(input logic [31:0] st);
    logic [31:0] r;
    r = st;
    r[OWN_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/ndma_base_reg.sv
module ndma_base_reg #(
  parameter int          CFG_AW   = 9,
  parameter int          AW       = 32,
  parameter int unsigned BASE_OFS = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [AW-1:0]     base_addr
);
  logic hit;
  assign hit = cfg_we && (cfg_addr == CFG_AW'(BASE_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n)   base_addr <= '0;
    else if (hit) base_addr <= cfg_wdata[AW-1:0];
  end
endmodule

// File: rtl/ndma_walker.sv
module ndma_walker #(
  parameter int AW    = 32,
  parameter int CNT_W = 9,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             step,
  output logic [AW-1:0]    addr,
  output logic             last,
  output logic             empty
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= load_addr;
      remain <= load_cnt;
    end else if (step) begin
      addr   <= addr + AW'(STEP);
      remain <= remain - 1'b1;
    end
  end

  assign last  = (remain == CNT_W'(1));
  assign empty = (remain == '0);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty);
endmodule

// File: rtl/ndma_engine.sv
module ndma_engine
  import ndma_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          CFG_AW   = 9,
  parameter int unsigned BASE_OFS = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cmd_start,
  input  logic              cmd_dir,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              tx_valid,
  output logic [63:0]       tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [63:0]       rx_data,
  output logic              rx_ready,
  output logic              irq_tx_done,
  output logic              irq_rx_done,
  output logic              irq_desc_unavail
);
  localparam int BYTES = 1 << BEAT_SH;

  ndma_state_t      state_q;
  logic             dir_q;
  logic [AW-1:0]    desc_q;
  logic [31:0]      status_q;
  logic [CNT_W-1:0] beats_q;
  logic [63:0]      data_q;
  logic [AW-1:0]    base_addr, walk_addr;
  logic             walk_last, walk_empty;

  // named internal events
  logic accept, fetch0_ack, fetch1_ack, txrd_ack, tx_take, rx_take, rxwr_ack, wb_ack;
  logic beat_step;
  assign accept     = (state_q == S_IDLE) && cmd_start;
  assign fetch0_ack = (state_q == S_FETCH0) && mem_ack;
  assign fetch1_ack = (state_q == S_FETCH1) && mem_ack;
  assign txrd_ack   = (state_q == S_TX_RD) && mem_ack;
  assign tx_take    = (state_q == S_TX_PUSH) && tx_ready;
  assign rx_take    = (state_q == S_RX_POP) && rx_valid;
  assign rxwr_ack   = (state_q == S_RX_WR) && mem_ack;
  assign wb_ack     = (state_q == S_WBACK) && mem_ack;
  assign beat_step  = tx_take || rxwr_ack;

  ndma_base_reg #(.CFG_AW(CFG_AW), .AW(AW), .BASE_OFS(BASE_OFS)) u_base (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .base_addr(base_addr)
  );

  ndma_walker #(.AW(AW), .CNT_W(CNT_W), .STEP(BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(fetch1_ack), .load_addr(mem_rdata[AW-1:0]),
    .load_cnt(beats_q), .step(beat_step), .addr(walk_addr),
    .last(walk_last), .empty(walk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q          <= S_IDLE;
      dir_q            <= 1'b0;
      desc_q           <= '0;
      status_q         <= '0;
      beats_q          <= '0;
      data_q           <= '0;
      irq_tx_done      <= 1'b0;
      irq_rx_done      <= 1'b0;
      irq_desc_unavail <= 1'b0;
    end else begin
      irq_tx_done      <= 1'b0;
      irq_rx_done      <= 1'b0;
      irq_desc_unavail <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          dir_q   <= cmd_dir;
          desc_q  <= base_addr;
          state_q <= S_FETCH0;
        end
        S_FETCH0: if (fetch0_ack) begin
          status_q <= mem_rdata[31:0];
          beats_q  <= beats_of(mem_rdata[63:32]);
          if (desc_usable(mem_rdata[31:0])) state_q <= S_FETCH1;
          else begin
            irq_desc_unavail <= 1'b1;
            state_q          <= S_IDLE;
          end
        end
        S_FETCH1: if (fetch1_ack) begin
          if (beats_q == '0) state_q <= S_WBACK;
          else               state_q <= dir_q ? S_RX_POP : S_TX_RD;
        end
        S_TX_RD: if (txrd_ack) begin
          data_q  <= mem_rdata;
          state_q <= S_TX_PUSH;
        end
        S_TX_PUSH: if (tx_take) state_q <= walk_last ? S_WBACK : S_TX_RD;
        S_RX_POP: if (rx_take) begin
          data_q  <= rx_data;
          state_q <= S_RX_WR;
        end
        S_RX_WR: if (rxwr_ack) state_q <= walk_last ? S_WBACK : S_RX_POP;
        S_WBACK: if (wb_ack) begin
          irq_tx_done <= !dir_q;
          irq_rx_done <= dir_q;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    mem_be    = 8'hFF;
    unique case (state_q)
      S_FETCH0: mem_req = 1'b1;
      S_FETCH1: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + AW'(BYTES);
      end
      S_TX_RD: begin
        mem_req  = 1'b1;
        mem_addr = walk_addr;
      end
      S_RX_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = walk_addr;
        mem_wdata = data_q;
      end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {32'h0, status_release(status_q)};
        mem_be    = 8'h0F;
      end
      default: ;
    endcase
  end

  assign busy     = (state_q != S_IDLE);
  assign tx_valid = (state_q == S_TX_PUSH);
  assign tx_data  = data_q;
  assign rx_ready = (state_q == S_RX_POP);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid && !rx_ready));
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_be) && $stable(mem_wdata)));
  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R9
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_tx_done, irq_rx_done, irq_desc_unavail}));
  // R9
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx_done || irq_rx_done) |-> $past(mem_ack && mem_we && mem_be == 8'h0F));
  // R4
  unavail_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_desc_unavail |-> ($past(mem_ack && !mem_we) && !busy));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start && !wb_ack && !fetch0_ack) |=> busy);
endmodule

// File: tb/tb_ndma_engine.sv
module tb_ndma_engine;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [8:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic cmd_start = 0, cmd_dir = 0;
  logic busy, mem_req, mem_we; logic [31:0] mem_addr; logic [63:0] mem_wdata;
  logic [7:0] mem_be; logic mem_ack = 0; logic [63:0] mem_rdata = 0;
  logic tx_valid; logic [63:0] tx_data; logic tx_ready = 0;
  logic rx_valid = 0; logic [63:0] rx_data = 0; logic rx_ready;
  logic irq_tx_done, irq_rx_done, irq_desc_unavail;

  always #(CLK_P/2) clk = ~clk;

  ndma_engine dut (.*);

  typedef struct { bit we; logic [31:0] addr; logic [63:0] wdata; logic [7:0] be; logic [2:0] irq; } acc_t;
  acc_t        exp_q[$];
  logic [63:0] tx_exp[$];
  logic [63:0] rx_src[$];
  logic [63:0] mem [0:2047];
  logic [2:0]  irq_exp_next = 0;
  int n_chk = 0, n_fail = 0, cyc = 0, wait_cnt = 0, lat_sel = 0;
  bit pend_pop = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] bemask(input logic [7:0] be);
    logic [63:0] m;
    for (int k = 0; k < 8; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction

  // reference model: memory responder, transmit sink, receive source, interrupts
  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk({irq_desc_unavail, irq_rx_done, irq_tx_done} === irq_exp_next, "R9/R4 irq",
        {irq_desc_unavail, irq_rx_done, irq_tx_done}, irq_exp_next);
    irq_exp_next = 0;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        acc_t e;
        mem_ack = 1;
        if (exp_q.size() == 0) chk(0, "R11/R4 unexpected access", mem_addr, 0);
        else begin
          e = exp_q.pop_front();
          chk(mem_we === e.we && mem_addr === e.addr && mem_be === e.be,
              "R3/R5/R8 access", {mem_be, 23'h0, mem_we, mem_addr}, {e.be, 23'h0, e.we, e.addr});
          if (e.we)
            chk((mem_wdata & bemask(e.be)) === (e.wdata & bemask(e.be)), "R7/R8 wdata",
                mem_wdata & bemask(e.be), e.wdata & bemask(e.be));
          irq_exp_next = e.irq;
        end
        if (mem_we) mem[mem_addr[13:3]] = (mem[mem_addr[13:3]] & ~bemask(mem_be)) | (mem_wdata & bemask(mem_be));
        else        mem_rdata = mem[mem_addr[13:3]];
        lat_sel = (lat_sel + 1) % 3;
        wait_cnt = lat_sel;
      end
    end
    tx_ready = (cyc % 3) != 0;
    if (tx_valid && tx_ready) begin
      if (tx_exp.size() == 0) chk(0, "R6 unexpected tx beat", tx_data, 0);
      else begin
        logic [63:0] t;
        t = tx_exp.pop_front();
        chk(tx_data === t, "R6 tx data", tx_data, t);
      end
    end
    if (pend_pop) begin void'(rx_src.pop_front()); pend_pop = 0; end
    rx_valid = (rx_src.size() != 0) && ((cyc % 4) != 1);
    rx_data  = (rx_src.size() != 0) ? rx_src[0] : 64'h0;
    if (rx_valid && rx_ready) pend_pop = 1;
  end

  task automatic cfg_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic put_desc(input logic [31:0] a, st, sz, p0, p1);
    mem[a[13:3]] = {sz, st};
    mem[a[13:3] + 1] = {p1, p0};
  endtask

  // build the expected access sequence from the requirements
  task automatic expect_xfer(input logic [31:0] base, input bit dir);
    logic [31:0] st, sz, p0; int nb; acc_t e;
    st = mem[base[13:3]][31:0]; sz = mem[base[13:3]][63:32]; p0 = mem[base[13:3] + 1][31:0];
    if (!(st[31] && st[3] && st[2])) begin
      exp_q.push_back('{0, base, 64'h0, 8'hFF, 3'b100});
      return;
    end
    exp_q.push_back('{0, base, 64'h0, 8'hFF, 3'b000});
    exp_q.push_back('{0, base + 8, 64'h0, 8'hFF, 3'b000});
    nb = sz[11:3];
    for (int i = 0; i < nb; i++) begin
      if (!dir) begin
        exp_q.push_back('{0, p0 + 8*i, 64'h0, 8'hFF, 3'b000});
        tx_exp.push_back(mem[(p0 + 8*i) >> 3]);
      end else begin
        logic [63:0] w;
        w = {32'hC0DE0000 + i, base ^ (32'h1111 * i)};
        rx_src.push_back(w);
        exp_q.push_back('{1, p0 + 8*i, w, 8'hFF, 3'b000});
      end
    end
    e = '{1, base, {32'h0, st & 32'h7FFFFFFF}, 8'h0F, dir ? 3'b010 : 3'b001};
    exp_q.push_back(e);
  endtask

  task automatic start(input bit dir);
    @(negedge clk); cmd_start = 1; cmd_dir = dir;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic wait_done(input string req);
    while (exp_q.size() != 0 || tx_exp.size() != 0 || rx_src.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, req, busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = {32'h5A000000 + i, 32'hA5000000 + i};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, mem_req, tx_valid, rx_ready, irq_tx_done, irq_rx_done, irq_desc_unavail} === 7'b0,
        "R1 reset", {busy, mem_req, tx_valid, rx_ready, irq_tx_done, irq_rx_done, irq_desc_unavail}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && mem_req === 0, "R1 idle after reset", {busy, mem_req}, 0);

    // R2: base at 0x18; write to another offset ignored. TX of 4 beats, R6
    cfg_write(9'h18, 32'h100);
    cfg_write(9'h10, 32'h500);
    put_desc(32'h100, 32'h8000000C, 32'h00000020, 32'h400, 32'hDEADBEE8);
    expect_xfer(32'h100, 0);
    start(0);
    wait_done("R6 tx done");
    chk(mem[32'h100 >> 3] === {32'h00000020, 32'h0000000C}, "R8 status released",
        mem[32'h100 >> 3], {32'h00000020, 32'h0000000C});

    // R4: same descriptor now owned by software -> unavailable
    expect_xfer(32'h100, 0);
    start(0);
    wait_done("R4 unavail idle");

    // R7: RX of 3 beats with stalls
    cfg_write(9'h18, 32'h200);
    put_desc(32'h200, 32'h8000000C, 32'h00000018, 32'h600, 32'h0);
    expect_xfer(32'h200, 1);
    start(1);
    wait_done("R7 rx done");
    for (int i = 0; i < 3; i++)
      chk(mem[(32'h600 >> 3) + i] === {32'hC0DE0000 + i, 32'h200 ^ (32'h1111 * i)}, "R7 rx memory",
          mem[(32'h600 >> 3) + i], {32'hC0DE0000 + i, 32'h200 ^ (32'h1111 * i)});

    // R10: size zero
    cfg_write(9'h18, 32'h280);
    put_desc(32'h280, 32'h8000000C, 32'hFFFFF000, 32'h700, 32'h0);
    expect_xfer(32'h280, 0);
    start(0);
    wait_done("R10 zero size");

    // R5: size 0x00F with junk upper bits -> one RX beat
    cfg_write(9'h18, 32'h2C0);
    put_desc(32'h2C0, 32'h8000000C, 32'hABCDE00F, 32'h740, 32'h0);
    expect_xfer(32'h2C0, 1);
    start(1);
    wait_done("R5 size field");

    // R4: first-only descriptor rejected
    cfg_write(9'h18, 32'h300);
    put_desc(32'h300, 32'h80000008, 32'h00000010, 32'h780, 32'h0);
    expect_xfer(32'h300, 0);
    start(0);
    wait_done("R4 first only");

    // R11/R2: start and base write while busy are ignored
    cfg_write(9'h18, 32'h340);
    put_desc(32'h340, 32'h8000000C, 32'h00000040, 32'h800, 32'h0);
    expect_xfer(32'h340, 0);
    start(0);
    repeat (8) @(negedge clk);
    chk(busy === 1'b1, "R11 busy mid transfer", busy, 1);
    start(1);
    cfg_write(9'h18, 32'h380);
    wait_done("R11 busy start ignored");

    // R5: largest beat count
    cfg_write(9'h18, 32'h3C0);
    put_desc(32'h3C0, 32'h8000000C, 32'h00000FFF, 32'h1000, 32'h0);
    expect_xfer(32'h3C0, 0);
    start(0);
    wait_done("R5 max size");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule